// File: doc/BRIEF.md
# Serial CRC-ITU Shift Register

This block computes the 16-bit CRC-ITU checksum one bit per clock. The generator is x^16 + x^12 + x^5 + 1. Data enters least significant bit first, so the register is held in reflected form. It shifts toward bit 0, and the reversed feedback mask 0x8408 is applied whenever the feedback bit is one. The same register serves both sides of a link. A sender clears the register to all ones, shifts in the payload, and transmits the complement of the register as the frame check sequence (FCS), low byte first. A receiver shifts in the payload followed by both FCS bytes. An undamaged frame always leaves the constant 0xF0B8 in the register.

The surrounding logic serialises bytes, decides where frames start and end, and inserts or strips the FCS. This block only advances its register when it accepts a bit, restarts it on command, and shows three views of its state: the raw register, its complement, and a flag that compares the register with the good-frame residue.

Top module: `crc_itu_serial`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register is loaded with 0xFFFF. `crc_reg_o` shows 0xFFFF from the following cycle.
- R2: When `init_i` is high at a clock edge, the register becomes 0xFFFF. This holds even if `bit_vld_i` is high in the same cycle, and that bit is discarded.
- R3: At an edge where neither `init_i` nor `bit_vld_i` is high, the register keeps its value, whatever `bit_i` carries.
- R4: At an edge where `bit_vld_i` is high and `init_i` is low, the feedback bit is f = reg[0] XOR `bit_i`. The new register is (reg >> 1) XOR (f ? 0x8408 : 0x0000). Equivalently, stage 15 takes f, stage 10 takes reg[11]^f, stage 3 takes reg[4]^f, and every other stage takes the next higher stage.
- R5: `crc_fcs_o` always equals the bitwise complement of `crc_reg_o`, with no added cycle.
- R6: `residue_ok_o` is high exactly when `crc_reg_o` equals 0xF0B8, with no added cycle.
- R7: Clear the register and shift in payload bytes, each byte LSB first. Then shift in the low byte and then the high byte of the `crc_fcs_o` value read after the payload. The register then holds 0xF0B8. Any single-bit change in those FCS bytes leaves `residue_ok_o` low.
- R8: An accepted bit changes `crc_reg_o` only after the clock edge that samples it. Bits on consecutive cycles are each accepted once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| init_i | input | 1 | Restart the register at all ones; wins over a valid bit |
| bit_vld_i | input | 1 | `bit_i` carries a bit to be shifted in this cycle |
| bit_i | input | 1 | Serial data bit, least significant bit of each byte first |
| crc_reg_o | output | 16 | Current register contents |
| crc_fcs_o | output | 16 | Complement of the register, the FCS to transmit |
| residue_ok_o | output | 1 | Register equals the good-frame residue 0xF0B8 |

## Verification
Every register change is due one clock after the edge that samples the command. Both derived outputs follow the register with no further delay. The bench therefore drives inputs on falling edges and reads all three outputs on the next falling edge, half a period after the update. A check taken just after a bit is driven, before the edge, confirms that nothing changes early. For multi-byte streams, the valid strobe is held high across consecutive cycles. The outputs are compared only after the falling edge that follows the last bit, so each bit's edge is counted exactly once.

// File: rtl/crc_itu_pkg.sv
package crc_itu_pkg;

    localparam int unsigned CRC_W          = 16;
    localparam logic [15:0] CRC_MASK_REFL  = 16'h8408;
    localparam logic [15:0] CRC_SEED       = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD_RES   = 16'hF0B8;

    // Command decoded from the control inputs, in priority order
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_SHIFT = 2'd1,
        CMD_SEED  = 2'd2
    } crc_cmd_e;

endpackage

// File: rtl/crc_itu_step.sv
module crc_itu_step #(
    parameter int unsigned      WIDTH = crc_itu_pkg::CRC_W,
    parameter logic [WIDTH-1:0] MASK  = crc_itu_pkg::CRC_MASK_REFL
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic             din_i,
    output logic [WIDTH-1:0] nxt_o
);

    localparam int unsigned TOP = WIDTH - 1;

    logic fb;

    always_comb begin
        fb = cur_i[0] ^ din_i;
    end

    for (genvar s = 0; s < WIDTH; s++) begin : g_stage
        if (s == TOP) begin : g_top
            always_comb nxt_o[s] = fb & MASK[s];
        end else if (MASK[s]) begin : g_tap
            always_comb nxt_o[s] = cur_i[s+1] ^ fb;
        end else begin : g_pass
            always_comb nxt_o[s] = cur_i[s+1];
        end
    end

endmodule

// File: rtl/crc_itu_state.sv
module crc_itu_state
    import crc_itu_pkg::*;
#(
    parameter int unsigned      WIDTH = CRC_W,
    parameter logic [WIDTH-1:0] SEED  = CRC_SEED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             vld_i,
    input  logic [WIDTH-1:0] shifted_i,
    output logic [WIDTH-1:0] state_o
);

    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } state_t;

    state_t   st_d, st_q;
    crc_cmd_e cmd;

    always_comb begin
        if (init_i) begin
            cmd = CMD_SEED;
        end else if (vld_i) begin
            cmd = CMD_SHIFT;
        end else begin
            cmd = CMD_HOLD;
        end

        st_d = st_q;
        unique case (cmd)
            CMD_SEED:  st_d.sr = SEED;
            CMD_SHIFT: st_d.sr = shifted_i;
            default:   st_d.sr = st_q.sr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sr <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q.sr;

endmodule

// File: rtl/crc_itu_view.sv
module crc_itu_view #(
    parameter int unsigned      WIDTH   = crc_itu_pkg::CRC_W,
    parameter logic [WIDTH-1:0] RESIDUE = crc_itu_pkg::CRC_GOOD_RES
) (
    input  logic [WIDTH-1:0] state_i,
    output logic [WIDTH-1:0] fcs_o,
    output logic             match_o
);

    always_comb begin
        fcs_o   = ~state_i;
        match_o = (state_i == RESIDUE);
    end

endmodule

// File: rtl/crc_itu_serial.sv
module crc_itu_serial
    import crc_itu_pkg::*;
#(
    parameter int unsigned      WIDTH   = CRC_W,
    parameter logic [WIDTH-1:0] MASK    = CRC_MASK_REFL,
    parameter logic [WIDTH-1:0] SEED    = CRC_SEED,
    parameter logic [WIDTH-1:0] RESIDUE = CRC_GOOD_RES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             bit_vld_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] crc_reg_o,
    output logic [WIDTH-1:0] crc_fcs_o,
    output logic             residue_ok_o
);

    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] nxt_d;

    crc_itu_step #(
        .WIDTH (WIDTH),
        .MASK  (MASK)
    ) step_i (
        .cur_i (cur_q),
        .din_i (bit_i),
        .nxt_o (nxt_d)
    );

    crc_itu_state #(
        .WIDTH (WIDTH),
        .SEED  (SEED)
    ) state_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_i),
        .vld_i     (bit_vld_i),
        .shifted_i (nxt_d),
        .state_o   (cur_q)
    );

    crc_itu_view #(
        .WIDTH   (WIDTH),
        .RESIDUE (RESIDUE)
    ) view_i (
        .state_i (cur_q),
        .fcs_o   (crc_fcs_o),
        .match_o (residue_ok_o)
    );

    assign crc_reg_o = cur_q;

endmodule

// File: rtl/crc_itu_serial_chk.sv
module crc_itu_serial_chk #(
    parameter int unsigned      WIDTH   = 16,
    parameter logic [WIDTH-1:0] MASK    = 16'h8408,
    parameter logic [WIDTH-1:0] SEED    = 16'hFFFF,
    parameter logic [WIDTH-1:0] RESIDUE = 16'hF0B8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_i,
    input logic             bit_vld_i,
    input logic             bit_i,
    input logic [WIDTH-1:0] crc_reg_o,
    input logic [WIDTH-1:0] crc_fcs_o,
    input logic             residue_ok_o
);

    // R1
    reset_seed_chk: assert property (@(posedge clk)
        !rst_n |=> crc_reg_o == SEED);

    // R2
    init_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> crc_reg_o == SEED);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !bit_vld_i) |=> $stable(crc_reg_o));

    // R4
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld_i && !init_i) |=>
            crc_reg_o == (($past(crc_reg_o) >> 1) ^
                          (($past(crc_reg_o[0]) ^ $past(bit_i)) ? MASK : '0)));

    // R5
    fcs_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_fcs_o ^ crc_reg_o) == {WIDTH{1'b1}});

    // R6
    residue_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        residue_ok_o == (crc_reg_o == RESIDUE));

endmodule

bind crc_itu_serial crc_itu_serial_chk #(
    .WIDTH   (WIDTH),
    .MASK    (MASK),
    .SEED    (SEED),
    .RESIDUE (RESIDUE)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_i       (init_i),
    .bit_vld_i    (bit_vld_i),
    .bit_i        (bit_i),
    .crc_reg_o    (crc_reg_o),
    .crc_fcs_o    (crc_fcs_o),
    .residue_ok_o (residue_ok_o)
);

// File: tb/crc_itu_serial_tb.sv
`timescale 1ns/1ps
module crc_itu_serial_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0;
    logic        bit_vld_i = 1'b0;
    logic        bit_i = 1'b0;
    logic [15:0] crc_reg_o;
    logic [15:0] crc_fcs_o;
    logic        residue_ok_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    crc_itu_serial dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_i       (init_i),
        .bit_vld_i    (bit_vld_i),
        .bit_i        (bit_i),
        .crc_reg_o    (crc_reg_o),
        .crc_fcs_o    (crc_fcs_o),
        .residue_ok_o (residue_ok_o)
    );

    function automatic logic [15:0] ref_bit(input logic [15:0] r, input logic b);
        logic [15:0] sh;
        sh = r >> 1;
        if (r[0] ^ b) sh = sh ^ 16'h8408;
        return sh;
    endfunction

    function automatic logic [15:0] ref_byte(input logic [15:0] r, input logic [7:0] v);
        logic [15:0] x;
        x = r;
        for (int j = 0; j < 8; j++) x = ref_bit(x, v[j]);
        return x;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic seed();
        @(negedge clk);
        init_i = 1'b1;
        @(negedge clk);
        init_i = 1'b0;
    endtask

    // Back-to-back bits, LSB first; returns after the edge of the last bit
    task automatic send_byte(input logic [7:0] v);
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            bit_vld_i = 1'b1;
            bit_i     = v[j];
        end
        @(negedge clk);
        bit_vld_i = 1'b0;
        bit_i     = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_r;
        logic [15:0] fcs;
        logic [7:0]  frame [11];

        repeat (3) @(negedge clk);
        // R1: reset value, and both views derived from it
        check("R1 reset reg", crc_reg_o, 16'hFFFF);
        check("R5 reset fcs", crc_fcs_o, 16'h0000);
        check("R6 reset flag", {15'd0, residue_ok_o}, 16'd0);
        rst_n = 1'b1;

        // R8: bit driven but edge not yet reached, register unchanged
        @(negedge clk);
        bit_vld_i = 1'b1;
        bit_i     = 1'b0;
        #1;
        check("R8 no early change", crc_reg_o, 16'hFFFF);
        @(negedge clk);
        bit_vld_i = 1'b0;
        check("R8 one edge later", crc_reg_o, ref_bit(16'hFFFF, 1'b0));

        // R3: idle cycles with a toggling data bit
        exp_r = crc_reg_o;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            bit_i = k[0];
        end
        @(negedge clk);
        check("R3 hold while idle", crc_reg_o, exp_r);

        // R2: init together with a valid bit
        send_byte(8'h5A);
        @(negedge clk);
        init_i    = 1'b1;
        bit_vld_i = 1'b1;
        bit_i     = 1'b1;
        @(negedge clk);
        init_i    = 1'b0;
        bit_vld_i = 1'b0;
        check("R2 init wins", crc_reg_o, 16'hFFFF);

        // R4/R5/R6/R7: exhaustive one-byte payloads with FCS round trip
        for (int v = 0; v < 256; v++) begin
            seed();
            send_byte(v[7:0]);
            exp_r = ref_byte(16'hFFFF, v[7:0]);
            check("R4 byte step", crc_reg_o, exp_r);
            check("R5 fcs", crc_fcs_o, ~exp_r);
            check("R6 flag after data", {15'd0, residue_ok_o},
                  {15'd0, exp_r == 16'hF0B8});
            fcs = crc_fcs_o;
            send_byte(fcs[7:0]);
            send_byte(fcs[15:8]);
            check("R7 residue", crc_reg_o, 16'hF0B8);
            check("R6 flag on residue", {15'd0, residue_ok_o}, 16'd1);
        end

        // R7: multi-byte frame with known FCS 0x3AD0
        frame = '{8'hFF, 8'h03, 8'hC0, 8'h21, 8'h04, 8'h03,
                  8'h00, 8'h07, 8'h0D, 8'h03, 8'h06};
        seed();
        exp_r = 16'hFFFF;
        for (int i = 0; i < 11; i++) begin
            send_byte(frame[i]);
            exp_r = ref_byte(exp_r, frame[i]);
        end
        check("R4 frame reg", crc_reg_o, exp_r);
        check("R7 frame fcs", crc_fcs_o, 16'h3AD0);
        send_byte(8'hD0);
        send_byte(8'h3A);
        check("R7 frame residue", crc_reg_o, 16'hF0B8);

        // R7: each single-bit error in the FCS clears the flag
        for (int e = 0; e < 16; e++) begin
            seed();
            for (int i = 0; i < 11; i++) send_byte(frame[i]);
            fcs = 16'h3AD0 ^ (16'h1 << e);
            send_byte(fcs[7:0]);
            send_byte(fcs[15:8]);
            check("R7 corrupted flag", {15'd0, residue_ok_o}, 16'd0);
        end

        // R1: reset mid-stream restores the seed
        send_byte(8'hC3);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset mid-stream", crc_reg_o, 16'hFFFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule